// File: doc/BRIEF.md
# Interrupt Controller Register Decoder

This block is the 32-bit register front end that sits between a memory-mapped bus and the priority arbiter of a platform interrupt controller. It decodes each word address into one of four windows:
- a per-source priority array;
- a read-only array of pending bits;
- per-target enable words at a fixed power-of-two stride;
- per-target context blocks at a power-of-two stride, each holding a threshold word and a claim/complete word.

For reads, it selects the matching value from state that the arbiter presents. For writes, it issues a single-cycle strobe with a target, an index and the write data. Reading the claim/complete word triggers a claim for that target. Writing it reports a completion.

Bus requests use a valid/ready handshake, and responses use a second valid/ready pair. A request is accepted only when `req_valid_i` and `req_ready_o` are both high. `req_ready_o` is high whenever no response is waiting, or when the waiting response is consumed in the same cycle. A response stays valid, with stable data and error flag, until `rsp_ready_i` is seen high. Every strobe, and the error pulse, appears in the cycle after acceptance, together with the new response. Because of this, a request that is stalled behind an unconsumed response has no side effect until it is accepted.

Top module: `intc_regdec`

## Requirements
- R1: An access with address bit 1 or bit 0 set is an error: its response has the error flag set and read data 0, and it raises no strobe.
- R2: Priority window: word k (address PRIO_BASE + 4k, for k below NSRC) is source k+1. A read returns that source's priority zero-extended. A write raises the priority strobe with `sel_o` = k+1.
- R3: Pending window: word w (PEND_BASE + 4w, w below NWORDS) reads bits 32w..32w+31 of the pending vector, where bit i is source ID i. A write there is an error and raises no strobe.
- R4: Enable window: the target is (address - ENA_BASE) / ENA_STRIDE and the word is ((address - ENA_BASE) mod ENA_STRIDE) / 4. A word at or above NWORDS is an error. Reads return the enable word. Writes raise the enable strobe with `tgt_o` and `sel_o` = word.
- R5: Context window, within-target offset 0: a read returns the target's threshold, and a write raises the threshold strobe for that target.
- R6: A read of context offset 4 returns the arbiter's claim ID for that target. It also raises exactly one claim strobe, with `tgt_o` and `sel_o` = that ID, in the response cycle.
- R7: A write to context offset 4 raises the completion strobe with `tgt_o` and `sel_o` = the low ID_W bits of the written data, with `wdata_o` = the full written data.
- R8: An aligned address outside all four windows, or any context offset other than 0 or 4, is an error with read data 0 and no strobe.
- R9: `err_pulse_o` is high for exactly one cycle per invalid accepted access. At most one strobe is high in any cycle. Strobes and the pulse appear only in the cycle after an acceptance.
- R10: While a response is valid and `rsp_ready_i` is low, `req_ready_o` is low, the response data and error flag hold, and a waiting request causes no strobe.
- R11: After reset, `rsp_valid_o`, `err_pulse_o` and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready |
| req_addr_i | input | ADDR_W | Byte address |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response ready |
| rsp_rdata_o | output | 32 | Read data (0 for writes and errors) |
| rsp_err_o | output | 1 | Response error flag |
| err_pulse_o | output | 1 | One-cycle pulse per invalid access |
| src_prio_i | input | NSRC*PRIO_W | Priority of source s at [(s-1)*PRIO_W +: PRIO_W] |
| pend_i | input | NWORDS*32 | Pending vector, bit i = source ID i |
| ena_i | input | NTGT*NWORDS*32 | Enable word w of target t at [(t*NWORDS+w)*32 +: 32] |
| thr_i | input | NTGT*PRIO_W | Threshold of target t at [t*PRIO_W +: PRIO_W] |
| claim_id_i | input | NTGT*ID_W | Arbiter's current claim ID for target t at [t*ID_W +: ID_W] |
| prio_we_o | output | 1 | Priority write strobe |
| ena_we_o | output | 1 | Enable word write strobe |
| thr_we_o | output | 1 | Threshold write strobe |
| claim_o | output | 1 | Claim strobe |
| cmpl_o | output | 1 | Completion strobe |
| tgt_o | output | TGT_W | Target of the strobe |
| sel_o | output | ID_W | Source ID or word index of the strobe |
| wdata_o | output | 32 | Write data of the strobe |

## Verification
Two things can happen in the same cycle: a response is consumed, and the next request is accepted. This matters most for claim reads, since each acceptance must produce exactly one claim strobe. The bench holds `req_valid_i` high on a claim address for several consecutive cycles with `rsp_ready_i` high, and expects one claim strobe per cycle. It then holds a claim request behind an unconsumed response, with `rsp_ready_i` low, and expects no strobe at all until the response is released. After release, it expects exactly one strobe. Each cycle, a per-clock monitor compares the strobes against the acceptances the bench itself observed on the previous edge.

// File: rtl/intc_regdec_pkg.sv
package intc_regdec_pkg;
  // Register window selected by the address decoder
  typedef enum logic [2:0] {
    RG_NONE, RG_PRIO, RG_PEND, RG_ENA, RG_THR, RG_CLAIM
  } reg_e;

  // Strobe registered toward the arbiter
  typedef enum logic [2:0] {
    OP_NONE, OP_PRIO_WR, OP_ENA_WR, OP_THR_WR, OP_CLAIM, OP_CMPL
  } op_e;
endpackage

// File: rtl/intc_regdec_decode.sv
module intc_regdec_decode
  import intc_regdec_pkg::*;
#(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned NSRC       = 40,
  parameter int unsigned NTGT       = 2,
  parameter int unsigned NWORDS     = 2,
  parameter int unsigned ID_W       = 6,
  parameter int unsigned TGT_W      = 1,
  parameter int unsigned PRIO_BASE  = 32'h4,
  parameter int unsigned PEND_BASE  = 32'h1000,
  parameter int unsigned ENA_BASE   = 32'h2000,
  parameter int unsigned ENA_STRIDE = 32'h80,
  parameter int unsigned CTX_BASE   = 32'h10000,
  parameter int unsigned CTX_STRIDE = 32'h1000
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output reg_e              kind_o,
  output logic [TGT_W-1:0]  tgt_o,
  output logic [ID_W-1:0]   idx_o,
  output logic              bad_o
);
  localparam int unsigned PRIO_END = PRIO_BASE + NSRC * 4;
  localparam int unsigned PEND_END = PEND_BASE + NWORDS * 4;
  localparam int unsigned ENA_END  = ENA_BASE + NTGT * ENA_STRIDE;
  localparam int unsigned CTX_END  = CTX_BASE + NTGT * CTX_STRIDE;
  localparam int unsigned ENA_SH   = $clog2(ENA_STRIDE);
  localparam int unsigned CTX_SH   = $clog2(CTX_STRIDE);

  logic [31:0] a, off, inner;

  always_comb begin
    kind_o = RG_NONE;
    tgt_o  = '0;
    idx_o  = '0;
    bad_o  = 1'b1;
    a      = 32'(addr_i);
    off    = '0;
    inner  = '0;
    if (a[1:0] == 2'b00) begin
      if (a >= PRIO_BASE && a < PRIO_END) begin
        off    = a - PRIO_BASE;
        kind_o = RG_PRIO;
        idx_o  = ID_W'((off >> 2) + 1);   // word k is source k+1
        bad_o  = 1'b0;
      end else if (a >= PEND_BASE && a < PEND_END) begin
        off = a - PEND_BASE;
        if (!we_i) begin                  // read-only window
          kind_o = RG_PEND;
          idx_o  = ID_W'(off >> 2);
          bad_o  = 1'b0;
        end
      end else if (a >= ENA_BASE && a < ENA_END) begin
        off   = a - ENA_BASE;
        tgt_o = TGT_W'(off >> ENA_SH);
        inner = (off & (ENA_STRIDE - 1)) >> 2;
        if (inner < NWORDS) begin
          kind_o = RG_ENA;
          idx_o  = ID_W'(inner);
          bad_o  = 1'b0;
        end
      end else if (a >= CTX_BASE && a < CTX_END) begin
        off   = a - CTX_BASE;
        tgt_o = TGT_W'(off >> CTX_SH);
        inner = off & (CTX_STRIDE - 1);
        if (inner == 32'd0) begin
          kind_o = RG_THR;
          bad_o  = 1'b0;
        end else if (inner == 32'd4) begin
          kind_o = RG_CLAIM;
          bad_o  = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/intc_regdec_rdmux.sv
module intc_regdec_rdmux
  import intc_regdec_pkg::*;
#(
  parameter int unsigned NSRC   = 40,
  parameter int unsigned NTGT   = 2,
  parameter int unsigned NWORDS = 2,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned ID_W   = 6,
  parameter int unsigned TGT_W  = 1
) (
  input  reg_e                     kind_i,
  input  logic [TGT_W-1:0]         tgt_i,
  input  logic [ID_W-1:0]          idx_i,
  input  logic [NSRC*PRIO_W-1:0]   src_prio_i,
  input  logic [NWORDS*32-1:0]     pend_i,
  input  logic [NTGT*NWORDS*32-1:0] ena_i,
  input  logic [NTGT*PRIO_W-1:0]   thr_i,
  input  logic [NTGT*ID_W-1:0]     claim_id_i,
  output logic [31:0]              rdata_o
);
  localparam int unsigned NIDX = 2 ** ID_W;
  localparam int unsigned NTSL = 2 ** TGT_W;

  logic [PRIO_W-1:0] prio_a [NIDX];
  logic [31:0]       pend_a [NIDX];
  logic [31:0]       ena_a  [NTSL][NIDX];
  logic [PRIO_W-1:0] thr_a  [NTSL];
  logic [ID_W-1:0]   cid_a  [NTSL];

  // Unpack the flat arbiter vectors into index-addressable slots; unused slots read 0
  for (genvar s = 0; s < NIDX; s++) begin : g_idx
    if (s >= 1 && s <= NSRC) begin : g_prio
      assign prio_a[s] = src_prio_i[(s-1)*PRIO_W +: PRIO_W];
    end else begin : g_prio_nil
      assign prio_a[s] = '0;
    end
    if (s < NWORDS) begin : g_pend
      assign pend_a[s] = pend_i[s*32 +: 32];
    end else begin : g_pend_nil
      assign pend_a[s] = '0;
    end
  end

  for (genvar t = 0; t < NTSL; t++) begin : g_tgt
    if (t < NTGT) begin : g_on
      assign thr_a[t] = thr_i[t*PRIO_W +: PRIO_W];
      assign cid_a[t] = claim_id_i[t*ID_W +: ID_W];
      for (genvar w = 0; w < NIDX; w++) begin : g_w
        if (w < NWORDS) begin : g_ena
          assign ena_a[t][w] = ena_i[(t*NWORDS+w)*32 +: 32];
        end else begin : g_ena_nil
          assign ena_a[t][w] = '0;
        end
      end
    end else begin : g_off
      assign thr_a[t] = '0;
      assign cid_a[t] = '0;
      for (genvar w = 0; w < NIDX; w++) begin : g_w
        assign ena_a[t][w] = '0;
      end
    end
  end

  always_comb begin
    unique case (kind_i)
      RG_PRIO:  rdata_o = 32'(prio_a[idx_i]);
      RG_PEND:  rdata_o = pend_a[idx_i];
      RG_ENA:   rdata_o = ena_a[tgt_i][idx_i];
      RG_THR:   rdata_o = 32'(thr_a[tgt_i]);
      RG_CLAIM: rdata_o = 32'(cid_a[tgt_i]);
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/intc_regdec.sv
module intc_regdec
  import intc_regdec_pkg::*;
#(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned NSRC       = 40,
  parameter int unsigned NTGT       = 2,
  parameter int unsigned PRIO_W     = 3,
  parameter int unsigned PRIO_BASE  = 32'h4,
  parameter int unsigned PEND_BASE  = 32'h1000,
  parameter int unsigned ENA_BASE   = 32'h2000,
  parameter int unsigned ENA_STRIDE = 32'h80,
  parameter int unsigned CTX_BASE   = 32'h10000,
  parameter int unsigned CTX_STRIDE = 32'h1000,
  localparam int unsigned NWORDS    = (NSRC + 32) / 32,
  localparam int unsigned ID_W      = $clog2(NSRC + 1),
  localparam int unsigned TGT_W     = (NTGT > 1) ? $clog2(NTGT) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  output logic                      req_ready_o,
  input  logic [ADDR_W-1:0]         req_addr_i,
  input  logic                      req_we_i,
  input  logic [31:0]               req_wdata_i,
  output logic                      rsp_valid_o,
  input  logic                      rsp_ready_i,
  output logic [31:0]               rsp_rdata_o,
  output logic                      rsp_err_o,
  output logic                      err_pulse_o,
  input  logic [NSRC*PRIO_W-1:0]    src_prio_i,
  input  logic [NWORDS*32-1:0]      pend_i,
  input  logic [NTGT*NWORDS*32-1:0] ena_i,
  input  logic [NTGT*PRIO_W-1:0]    thr_i,
  input  logic [NTGT*ID_W-1:0]      claim_id_i,
  output logic                      prio_we_o,
  output logic                      ena_we_o,
  output logic                      thr_we_o,
  output logic                      claim_o,
  output logic                      cmpl_o,
  output logic [TGT_W-1:0]          tgt_o,
  output logic [ID_W-1:0]           sel_o,
  output logic [31:0]               wdata_o
);
  reg_e             dec_kind;
  logic [TGT_W-1:0] dec_tgt;
  logic [ID_W-1:0]  dec_idx;
  logic             dec_bad;
  logic [31:0]      mux_rdata;
  op_e              nxt_op, op_q;
  logic [ID_W-1:0]  nxt_sel;
  logic             accept;

  intc_regdec_decode #(
    .ADDR_W(ADDR_W), .NSRC(NSRC), .NTGT(NTGT), .NWORDS(NWORDS), .ID_W(ID_W),
    .TGT_W(TGT_W), .PRIO_BASE(PRIO_BASE), .PEND_BASE(PEND_BASE),
    .ENA_BASE(ENA_BASE), .ENA_STRIDE(ENA_STRIDE), .CTX_BASE(CTX_BASE),
    .CTX_STRIDE(CTX_STRIDE)
  ) u_dec (
    .addr_i(req_addr_i), .we_i(req_we_i), .kind_o(dec_kind),
    .tgt_o(dec_tgt), .idx_o(dec_idx), .bad_o(dec_bad)
  );

  intc_regdec_rdmux #(
    .NSRC(NSRC), .NTGT(NTGT), .NWORDS(NWORDS), .PRIO_W(PRIO_W),
    .ID_W(ID_W), .TGT_W(TGT_W)
  ) u_mux (
    .kind_i(dec_kind), .tgt_i(dec_tgt), .idx_i(dec_idx),
    .src_prio_i(src_prio_i), .pend_i(pend_i), .ena_i(ena_i),
    .thr_i(thr_i), .claim_id_i(claim_id_i), .rdata_o(mux_rdata)
  );

  // A held response blocks new requests unless it drains this cycle
  assign req_ready_o = !rsp_valid_o || rsp_ready_i;
  assign accept      = req_valid_i && req_ready_o;

  always_comb begin
    nxt_op  = OP_NONE;
    nxt_sel = dec_idx;
    if (!dec_bad) begin
      unique case (dec_kind)
        RG_PRIO:  if (req_we_i) nxt_op = OP_PRIO_WR;
        RG_ENA:   if (req_we_i) nxt_op = OP_ENA_WR;
        RG_THR:   if (req_we_i) nxt_op = OP_THR_WR;
        RG_CLAIM: begin
          if (req_we_i) begin
            nxt_op  = OP_CMPL;
            nxt_sel = req_wdata_i[ID_W-1:0];
          end else begin
            nxt_op  = OP_CLAIM;
            nxt_sel = mux_rdata[ID_W-1:0];
          end
        end
        default: nxt_op = OP_NONE;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
      rsp_err_o   <= 1'b0;
      err_pulse_o <= 1'b0;
      op_q        <= OP_NONE;
      tgt_o       <= '0;
      sel_o       <= '0;
      wdata_o     <= '0;
    end else begin
      err_pulse_o <= 1'b0;
      op_q        <= OP_NONE;
      if (accept) begin
        rsp_valid_o <= 1'b1;
        rsp_err_o   <= dec_bad;
        err_pulse_o <= dec_bad;
        rsp_rdata_o <= (dec_bad || req_we_i) ? '0 : mux_rdata;
        op_q        <= nxt_op;
        tgt_o       <= dec_tgt;
        sel_o       <= nxt_sel;
        wdata_o     <= req_wdata_i;
      end else if (rsp_ready_i) begin
        rsp_valid_o <= 1'b0;
      end
    end
  end

  assign prio_we_o = (op_q == OP_PRIO_WR);
  assign ena_we_o  = (op_q == OP_ENA_WR);
  assign thr_we_o  = (op_q == OP_THR_WR);
  assign claim_o   = (op_q == OP_CLAIM);
  assign cmpl_o    = (op_q == OP_CMPL);
endmodule

// File: rtl/intc_regdec_chk.sv
module intc_regdec_chk #(
  parameter int unsigned ID_W = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic            rsp_valid_o,
  input logic            rsp_ready_i,
  input logic [31:0]     rsp_rdata_o,
  input logic            rsp_err_o,
  input logic            err_pulse_o,
  input logic            prio_we_o,
  input logic            ena_we_o,
  input logic            thr_we_o,
  input logic            claim_o,
  input logic            cmpl_o,
  input logic [ID_W-1:0] sel_o
);
  logic any_stb;
  assign any_stb = prio_we_o | ena_we_o | thr_we_o | claim_o | cmpl_o;

  // R9: never two strobes at once
  a_r9_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prio_we_o, ena_we_o, thr_we_o, claim_o, cmpl_o}));

  // R1 / R8: an invalid access responds with error, zero data and no strobe
  a_r8_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_pulse_o |-> (rsp_err_o && rsp_rdata_o == 32'd0 && !any_stb));

  // R9: a strobe or pulse follows an acceptance on the previous edge
  a_r9_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_stb || err_pulse_o) |-> $past(req_valid_i && req_ready_o));

  // R10: a held response blocks requests and keeps its contents
  a_r10_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |-> !req_ready_o);

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=>
      (rsp_valid_o && $stable(rsp_rdata_o) && $stable(rsp_err_o)));

  // R6: the claim strobe carries the ID returned on the bus
  a_r6_claim_id: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_o |-> (rsp_valid_o && rsp_rdata_o == 32'(sel_o)));

  // R11: strobes only come with a response
  a_r11_stb_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_stb |-> rsp_valid_o);
endmodule

bind intc_regdec intc_regdec_chk #(.ID_W(ID_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o), .rsp_valid_o(rsp_valid_o),
  .rsp_ready_i(rsp_ready_i), .rsp_rdata_o(rsp_rdata_o),
  .rsp_err_o(rsp_err_o), .err_pulse_o(err_pulse_o),
  .prio_we_o(prio_we_o), .ena_we_o(ena_we_o), .thr_we_o(thr_we_o),
  .claim_o(claim_o), .cmpl_o(cmpl_o), .sel_o(sel_o)
);

// File: tb/intc_regdec_test.sv
module intc_regdec_test;
  localparam int NSRC = 40, NTGT = 2, NW = 2, PW = 3, IDW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, rsp_ready = 1'b1;
  logic [23:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err, err_pulse;
  logic [31:0] rsp_rdata, wdata;
  logic prio_we, ena_we, thr_we, claim, cmpl;
  logic [0:0] tgt;
  logic [IDW-1:0] sel;
  logic [NSRC*PW-1:0] src_prio;
  logic [NW*32-1:0] pend;
  logic [NTGT*NW*32-1:0] ena;
  logic [NTGT*PW-1:0] thr;
  logic [NTGT*IDW-1:0] cid;

  int prio_v [NSRC+1];
  logic [31:0] pend_v [NW];
  logic [31:0] ena_v [NTGT][NW];
  int thr_v [NTGT] = '{3, 6};
  int cid_v [NTGT] = '{5, 37};
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0, acc_q = 0;

  always #10 clk = ~clk;

  intc_regdec uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_we_i(req_we), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_rdata_o(rsp_rdata),
    .rsp_err_o(rsp_err), .err_pulse_o(err_pulse), .src_prio_i(src_prio),
    .pend_i(pend), .ena_i(ena), .thr_i(thr), .claim_id_i(cid),
    .prio_we_o(prio_we), .ena_we_o(ena_we), .thr_we_o(thr_we), .claim_o(claim),
    .cmpl_o(cmpl), .tgt_o(tgt), .sel_o(sel), .wdata_o(wdata)
  );

  function automatic int obs_op();
    return prio_we ? 1 : ena_we ? 2 : thr_we ? 3 : claim ? 4 : cmpl ? 5 : 0;
  endfunction

  task automatic chk(input string req, input bit ok, input string act, input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  // Per-clock monitor (R9): nothing fires unless a request was accepted on the last edge
  always @(posedge clk) begin
    cyc++;
    acc_q <= rst_n && req_valid && req_ready;
  end
  always @(negedge clk) begin
    #1;
    if (rst_n && !acc_q)
      chk("R9 idle", !(err_pulse || obs_op() != 0),
          $sformatf("op=%0d pulse=%0d", obs_op(), err_pulse), "op=0 pulse=0");
  end

  // Behavioural reference for one access
  task automatic model(input int a, input bit w, input logic [31:0] d,
                       output bit e, output logic [31:0] rd, output int op,
                       output int t, output int s);
    e = 1; rd = 0; op = 0; t = 0; s = 0;
    if (a % 4 != 0) return;
    if (a >= 4 && a < 4 + 4*NSRC) begin
      s = (a - 4) / 4 + 1; e = 0;
      if (w) op = 1; else rd = prio_v[s];
    end else if (a >= 'h1000 && a < 'h1000 + 4*NW) begin
      if (!w) begin e = 0; rd = pend_v[(a - 'h1000) / 4]; end
    end else if (a >= 'h2000 && a < 'h2000 + NTGT*'h80) begin
      t = (a - 'h2000) / 'h80; s = ((a - 'h2000) % 'h80) / 4;
      if (s < NW) begin e = 0; if (w) op = 2; else rd = ena_v[t][s]; end
    end else if (a >= 'h10000 && a < 'h10000 + NTGT*'h1000) begin
      t = (a - 'h10000) / 'h1000;
      if ((a - 'h10000) % 'h1000 == 0) begin
        e = 0; if (w) op = 3; else rd = thr_v[t];
      end else if ((a - 'h10000) % 'h1000 == 4) begin
        e = 0;
        if (w) begin op = 5; s = d % 64; end
        else begin op = 4; s = cid_v[t]; rd = cid_v[t]; end
      end
    end
  endtask

  task automatic xact(input int a, input bit w, input logic [31:0] d, input string req);
    bit e; logic [31:0] rd; int op, t, s; bit ok;
    model(a, w, d, e, rd, op, t, s);
    @(negedge clk);
    req_valid = 1; req_addr = 24'(a); req_we = w; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    ok = rsp_valid && rsp_rdata == rd && rsp_err == e && err_pulse == e && obs_op() == op;
    if (op != 0) ok = ok && int'(tgt) == t && int'(sel) == s && (!w || wdata == d);
    chk(req, ok,
        $sformatf("v=%0d rd=%h err=%0d pulse=%0d op=%0d tgt=%0d sel=%0d",
                  rsp_valid, rsp_rdata, rsp_err, err_pulse, obs_op(), tgt, sel),
        $sformatf("v=1 rd=%h err=%0d pulse=%0d op=%0d tgt=%0d sel=%0d",
                  rd, e, e, op, t, s));
  endtask

  initial begin
    int n;
    for (int s = 1; s <= NSRC; s++) prio_v[s] = (s * 5) % 8;
    pend_v[0] = 32'hA5C3_0F1E; pend_v[1] = 32'h0000_01B6;
    ena_v[0][0] = 32'h1234_5678; ena_v[0][1] = 32'h0000_00F0;
    ena_v[1][0] = 32'hCAFE_0002; ena_v[1][1] = 32'h0000_0155;
    for (int s = 1; s <= NSRC; s++) src_prio[(s-1)*PW +: PW] = PW'(prio_v[s]);
    for (int w = 0; w < NW; w++) pend[w*32 +: 32] = pend_v[w];
    for (int t = 0; t < NTGT; t++) begin
      thr[t*PW +: PW] = PW'(thr_v[t]);
      cid[t*IDW +: IDW] = IDW'(cid_v[t]);
      for (int w = 0; w < NW; w++) ena[(t*NW+w)*32 +: 32] = ena_v[t][w];
    end

    repeat (3) @(negedge clk);
    chk("R11 reset", !rsp_valid && !err_pulse && obs_op() == 0,
        $sformatf("v=%0d pulse=%0d op=%0d", rsp_valid, err_pulse, obs_op()), "all 0");
    rst_n = 1;

    xact('h6, 0, 0, "R1 misaligned read");
    xact('h2001, 1, 32'hFFFF, "R1 misaligned write");
    xact('h4, 0, 0, "R2 word0 is source1");
    xact('h4 + 4*39, 0, 0, "R2 last source");
    xact('h8, 1, 32'h7, "R2 write source2");
    xact('h1000, 0, 0, "R3 pending word0");
    xact('h1004, 0, 0, "R3 pending word1");
    xact('h1000, 1, 32'hFFFF_FFFF, "R3 pending write rejected");
    xact('h2004, 0, 0, "R4 enable t0 w1");
    xact('h2080, 0, 0, "R4 enable t1 w0");
    xact('h2084, 1, 32'h55AA, "R4 enable write t1 w1");
    xact('h2008, 0, 0, "R4 word beyond range");
    xact('h11000, 0, 0, "R5 threshold read t1");
    xact('h10000, 1, 32'h2, "R5 threshold write t0");
    xact('h10004, 0, 0, "R6 claim t0");
    xact('h11004, 0, 0, "R6 claim t1");
    xact('h11004, 1, 32'd37, "R7 complete t1");
    xact('h0, 0, 0, "R8 below windows");
    xact('h3000, 1, 32'h1, "R8 gap");
    xact('h10008, 0, 0, "R8 unused ctx offset");
    xact('h12000, 0, 0, "R8 beyond ctx");

    // R10: claim held behind an unconsumed response
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_addr = 24'h4; req_we = 0;
    @(negedge clk);
    req_addr = 24'h10004;
    chk("R10 ready low", rsp_valid && !req_ready,
        $sformatf("v=%0d rdy=%0d", rsp_valid, req_ready), "v=1 rdy=0");
    n = 0;
    repeat (3) begin @(negedge clk); n += claim; end
    chk("R10 no claim while stalled", n == 0 && rsp_rdata == 32'(prio_v[1]),
        $sformatf("claims=%0d rd=%h", n, rsp_rdata), $sformatf("claims=0 rd=%h", prio_v[1]));
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R10 R6 claim after release", claim && rsp_rdata == 32'(cid_v[0]) && sel == IDW'(cid_v[0]),
        $sformatf("claim=%0d rd=%h", claim, rsp_rdata), $sformatf("claim=1 rd=%h", cid_v[0]));

    // R6: back-to-back claims while responses drain each cycle
    @(negedge clk);
    req_valid = 1; req_addr = 24'h11004; req_we = 0;
    n = 0;
    repeat (3) begin @(negedge clk); n += claim; end
    req_valid = 0;
    @(negedge clk); n += claim;
    chk("R6 one claim per accept", n == 3, $sformatf("claims=%0d", n), "claims=3");

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    wait (cyc >= 5000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule